// File: doc/BRIEF.md
# Lookup-Table Word Processing Element

This block is an 8-bit arithmetic and logic element whose function is not chosen by an opcode. It is built from one slice per data bit. Each slice holds two small truth tables, each eight entries deep. One table gives the slice's result bit. The other gives the carry that the slice passes to the slice above it. Both tables are read with the slice's operand bits and its incoming carry as the read address. The carry ripples upward from the external carry input to the carry output, so loading the right pair of tables turns the word into an adder, a subtractor, or any bitwise function of three inputs. Slices may also be loaded with different functions.

Tables are written one slice at a time through a word-wide configuration port: a slice index and a 16-bit table pair are presented while the write enable is high. The result word and the carry output are captured in registers on the rising clock edge. A synchronous reset clears those registers and every table.

Top module: `lut_word_pe`

## Requirements
- R1: While `rst` is high at a rising edge, `q`, `cout` and every stored table are set to zero. With all tables zero, any later operands give `q` = 0 and `cout` = 0 until new tables are written.
- R2: The read address of slice i is idx = {c_i, b[i], a[i]}, with the carry at bit 2, `b` at bit 1 and `a` at bit 0. The result bit of slice i is entry idx of its result table.
- R3: The carry into slice 0 is `cin`. The carry into slice i+1 is entry idx of slice i's carry table. `cout` is the carry leaving slice 7.
- R4: When `cfg_we` is high at a rising edge, `cfg_data[7:0]` becomes the result table and `cfg_data[15:8]` becomes the carry table of the slice numbered `cfg_sel`. Entry k of a table is bit k of its byte.
- R5: A write leaves the tables of every other slice unchanged.
- R6: `q` and `cout` show the function of the operands and `cin` that were present at the previous rising edge. That function uses the tables as they stood before any write made at the same edge.
- R7: With every slice loaded with 16'hE896, the element adds: {cout,q} = a + b + cin.
- R8: With every slice loaded with 16'hB269 and `cin` = 1, the element subtracts: q = a - b mod 256, and cout = 1 exactly when a >= b.
- R9: With tables 16'h0066 the element gives q = a ^ b, and with 16'h0088 it gives q = a & b. In both cases `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| a | input | 8 | Operand A |
| b | input | 8 | Operand B |
| cin | input | 1 | Carry into slice 0 |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 3 | Slice index for a table write |
| cfg_data | input | 16 | Table pair: carry table in [15:8], result table in [7:0] |
| q | output | 8 | Registered result word |
| cout | output | 1 | Registered carry out of slice 7 |

## Verification
The hardest case to reach from the ports is a configuration write that lands on the same edge as a computation. There, the captured result must still come from the old tables, while the next result must come from the new ones. The bench loads the adder everywhere, then rewrites slice 0 with an XOR table in the same cycle that it presents a carry-producing operand pair. It checks two consecutive results: one against the plain sum, and one against a sum in which bit 0 neither adds nor propagates a carry. Mixing slice functions in the same way also exposes any write that reaches the wrong slice.

// File: rtl/lut_pe_pkg.sv
package lut_pe_pkg;
  localparam int LUT_INPUTS = 3;
  localparam int LUT_DEPTH  = 1 << LUT_INPUTS;
  localparam int PAIR_W     = 2 * LUT_DEPTH;

  typedef logic [LUT_DEPTH-1:0]   lut_tbl_t;
  typedef logic [LUT_INPUTS-1:0]  lut_idx_t;

  // Read address: carry at the top, then b, then a.
  function automatic lut_idx_t lut_addr(input logic av, input logic bv, input logic cv);
    return {cv, bv, av};
  endfunction

  function automatic logic lut_read(input lut_tbl_t tbl, input lut_idx_t idx);
    return tbl[idx];
  endfunction
endpackage

// File: rtl/slice_table_store.sv
module slice_table_store
  import lut_pe_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int SLICE_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [PAIR_W-1:0] cfg_data,
  output lut_tbl_t          res_tbl,
  output lut_tbl_t          cry_tbl
);
  logic hit;
  assign hit = cfg_we && (cfg_sel == SEL_W'(SLICE_ID));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_tbl <= '0;
      cry_tbl <= '0;
    end else if (hit) begin
      res_tbl <= cfg_data[LUT_DEPTH-1:0];
      cry_tbl <= cfg_data[PAIR_W-1:LUT_DEPTH];
    end
  end

  // R1
  tbl_reset_chk: assert property (@(posedge clk) rst |=> (res_tbl == '0 && cry_tbl == '0));
  // R4
  tbl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_sel == SEL_W'(SLICE_ID)) |=> ({cry_tbl, res_tbl} == $past(cfg_data)));
  // R5
  tbl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(cfg_we && cfg_sel == SEL_W'(SLICE_ID)) |=> ($stable(res_tbl) && $stable(cry_tbl)));
endmodule

// File: rtl/slice_eval.sv
module slice_eval
  import lut_pe_pkg::*;
(
  input  logic     a_bit,
  input  logic     b_bit,
  input  logic     c_in,
  input  lut_tbl_t res_tbl,
  input  lut_tbl_t cry_tbl,
  output logic     r_bit,
  output logic     c_out
);
  lut_idx_t idx;
  assign idx   = lut_addr(a_bit, b_bit, c_in);
  assign r_bit = lut_read(res_tbl, idx);
  assign c_out = lut_read(cry_tbl, idx);
endmodule

// File: rtl/lut_word_pe.sv
module lut_word_pe
  import lut_pe_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [WIDTH-1:0]         a,
  input  logic [WIDTH-1:0]         b,
  input  logic                     cin,
  input  logic                     cfg_we,
  input  logic [$clog2(WIDTH)-1:0] cfg_sel,
  input  logic [PAIR_W-1:0]        cfg_data,
  output logic [WIDTH-1:0]         q,
  output logic                     cout
);
  localparam int SEL_W = $clog2(WIDTH);

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] word_next;

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    lut_tbl_t res_tbl;
    lut_tbl_t cry_tbl;

    slice_table_store #(.SEL_W(SEL_W), .SLICE_ID(i)) u_store (
      .clk      (clk),
      .rst      (rst),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_data (cfg_data),
      .res_tbl  (res_tbl),
      .cry_tbl  (cry_tbl)
    );

    slice_eval u_eval (
      .a_bit   (a[i]),
      .b_bit   (b[i]),
      .c_in    (carry[i]),
      .res_tbl (res_tbl),
      .cry_tbl (cry_tbl),
      .r_bit   (word_next[i]),
      .c_out   (carry[i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      cout <= 1'b0;
    end else begin
      q    <= word_next;
      cout <= carry[WIDTH];
    end
  end

  // R1
  out_reset_chk: assert property (@(posedge clk) rst |=> (q == '0 && !cout));
endmodule

// File: tb/lut_word_pe_tb.sv
module lut_word_pe_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] a, b;
  logic       cin;
  logic       cfg_we;
  logic [2:0] cfg_sel;
  logic [15:0] cfg_data;
  logic [7:0] q;
  logic       cout;

  int checks = 0;
  int fails  = 0;

  localparam logic [15:0] T_ADD = 16'hE896;
  localparam logic [15:0] T_SUB = 16'hB269;
  localparam logic [15:0] T_XOR = 16'h0066;
  localparam logic [15:0] T_AND = 16'h0088;

  always #2.5 clk = ~clk;

  lut_word_pe u_dut (
    .clk(clk), .rst(rst), .a(a), .b(b), .cin(cin),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .q(q), .cout(cout)
  );

  task automatic check(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got {cout,q}=%h expected %h", req, got, exp);
    end
  endtask

  task automatic write_slice(input int s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(s); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_all(input logic [15:0] d);
    for (int s = 0; s < 8; s++) write_slice(s, d);
  endtask

  // Drive at a falling edge, capture at the rising edge, sample at the next falling edge.
  task automatic run(input logic [7:0] av, input logic [7:0] bv, input logic cv,
                     input logic [8:0] exp, input string req);
    @(negedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
    check(req, {cout, q}, exp);
  endtask

  task automatic test_reset;
    // R1: outputs zero after reset and tables empty
    run(8'hFF, 8'h01, 1'b1, 9'h000, "R1 empty tables");
  endtask

  task automatic test_add;
    load_all(T_ADD);
    for (int n = 0; n < 20; n++) begin
      logic [7:0] av = 8'($urandom); logic [7:0] bv = 8'($urandom); logic cv = 1'($urandom);
      run(av, bv, cv, 9'(av) + 9'(bv) + 9'(cv), "R7 add");
    end
    run(8'hFF, 8'h00, 1'b1, 9'h100, "R3 ripple full chain");
    run(8'h80, 8'h80, 1'b0, 9'h100, "R3 cout from top slice");
  endtask

  task automatic test_sub;
    load_all(T_SUB);
    for (int n = 0; n < 20; n++) begin
      logic [7:0] av = 8'($urandom); logic [7:0] bv = 8'($urandom);
      run(av, bv, 1'b1, {av >= bv, 8'(av - bv)}, "R8 subtract");
    end
    run(8'h42, 8'h42, 1'b1, 9'h100, "R8 equal operands");
  endtask

  task automatic test_logic;
    load_all(T_XOR);
    for (int n = 0; n < 10; n++) begin
      logic [7:0] av = 8'($urandom); logic [7:0] bv = 8'($urandom);
      run(av, bv, 1'($urandom), {1'b0, av ^ bv}, "R9 xor");
    end
    load_all(T_AND);
    for (int n = 0; n < 10; n++) begin
      logic [7:0] av = 8'($urandom); logic [7:0] bv = 8'($urandom);
      run(av, bv, 1'($urandom), {1'b0, av & bv}, "R9 and");
    end
  endtask

  task automatic test_index;
    // R2: result table with only entry 4 (carry=1,b=0,a=0) set, carry tables empty
    load_all(16'h0010);
    run(8'h00, 8'h00, 1'b1, 9'h001, "R2 idx carry bit only slice 0");
    run(8'h00, 8'h00, 1'b0, 9'h000, "R2 idx no carry");
    // R2: only entry 2 (b=1) set
    load_all(16'h0004);
    run(8'h0F, 8'hF0, 1'b0, 9'h0F0, "R2 idx b bit");
  endtask

  task automatic test_isolation;
    // R5: slice 3 becomes AND, rest stay add
    load_all(T_ADD);
    write_slice(3, T_AND);
    run(8'h08, 8'h00, 1'b0, 9'h000, "R5 slice 3 changed");
    run(8'h04, 8'h04, 1'b0, 9'h000, "R5 carry into slice 3 dropped");
    run(8'h01, 8'h02, 1'b0, 9'h003, "R5 other slices still add");
    run(8'h80, 8'h80, 1'b0, 9'h100, "R5 slice 7 still add");
  endtask

  task automatic test_same_edge;
    // R6: write slice 0 with XOR at the edge that captures 1+1
    load_all(T_ADD);
    @(negedge clk);
    a = 8'h01; b = 8'h01; cin = 1'b0;
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_data = T_XOR;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R6 old tables at write edge", {cout, q}, 9'h002);
    @(negedge clk);
    check("R6 new tables next edge", {cout, q}, 9'h000);
  endtask

  task automatic test_reset_clears;
    load_all(T_ADD);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 outputs cleared", {cout, q}, 9'h000);
    rst = 1'b0;
    run(8'h05, 8'h03, 1'b1, 9'h000, "R1 tables cleared");
  endtask

  initial begin
    rst = 1'b1; a = '0; b = '0; cin = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {cout, q}, 9'h000);
    rst = 1'b0;
    test_reset();
    test_add();
    test_sub();
    test_logic();
    test_index();
    test_isolation();
    test_same_edge();
    test_reset_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule